// File: doc/BRIEF.md
# Ethernet Receive Frame Error Classifier

This block sits behind a receive deserializer and judges each frame as it closes. It counts the bytes of the frame and takes a bit count for the partial byte that trails the last whole one. When the frame ends it also takes a pass/fail result from an external CRC checker. From these it builds a receive event word that holds CRC, runt, oversize and trailing-bit flags. It also reports an alignment error when trailing bits and a CRC failure occur together.

Two 16-bit masks from the host control the outcome. The accept mask decides whether an errored frame is kept or dropped by the buffer manager. The interrupt mask decides which errors raise an interrupt. Both masks use the same bit positions as the event word. While bytes arrive, a store-enable tells the buffer manager which bytes to write, so an oversize frame never writes more than the maximum length. The verdict appears as a one-cycle result strobe on the clock after end of frame.

The control is a three-state machine. ST_IDLE means no frame is open. ST_RECV means a frame is collecting bytes. ST_DONE is the cycle in which the result is presented. The transitions are:
- ST_IDLE to ST_RECV on a byte without end of frame.
- ST_IDLE or ST_RECV to ST_DONE on end of frame.
- ST_DONE to ST_DONE on a back-to-back end of frame.
- ST_DONE to ST_RECV on a new byte.
- ST_DONE to ST_IDLE otherwise.

Top module: `rx_frame_classifier`

## Requirements
- R1: Bit 12 of `res_status` is set for a frame whose `crc_ok` was low at end of frame.
- R2: Bit 13 of `res_status` is set when the frame holds fewer than MIN_LEN bytes. A byte presented in the same cycle as `eof` counts toward the frame.
- R3: Bit 14 of `res_status` is set when the frame holds more than MAX_LEN bytes.
- R4: `byte_store` is high for a valid byte only when fewer than MAX_LEN bytes of the current frame precede it. It is low when no byte is valid.
- R5: Bit 7 of `res_status` is set when `eof_bits` is nonzero. The trailing bits do not change the byte length used by R2 and R3.
- R6: `res_align` is high in the result cycle exactly when bit 7 and bit 12 are both set for that frame.
- R7: `res_keep` is high for a frame with none of bits 12 to 14 set. Otherwise it is high only when every one of those bits that is set also has its bit set in `accept_mask`.
- R8: `irq` pulses in the result cycle when some bit among 12 to 14 is set in both `res_status` and `irq_mask`. It stays low otherwise.
- R9: `res_vld` is high for exactly one cycle, the clock after `eof`. All `res_status` bits other than 7, 12, 13 and 14 are zero.
- R10: After reset, `res_vld`, `irq` and `res_status` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| eof | input | 1 | End of frame; may coincide with the last byte |
| eof_bits | input | 3 | Leftover bits after the last whole byte, valid with eof |
| crc_ok | input | 1 | CRC check passed, valid with eof |
| accept_mask | input | 16 | Per-error keep enables (bits 12..14) |
| irq_mask | input | 16 | Per-error interrupt enables (bits 12..14) |
| byte_store | output | 1 | Write this byte into the frame buffer |
| res_vld | output | 1 | Result strobe, one cycle |
| res_status | output | 16 | Receive event word |
| res_keep | output | 1 | Keep (1) or discard (0) the frame |
| res_align | output | 1 | Alignment error |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with MIN_LEN = 4 and MAX_LEN = 10. With those values every length from empty up to three bytes beyond the maximum can be swept. That sweep covers both length thresholds and the truncation point on each side. For every length the bench tries both CRC outcomes, zero and nonzero trailing bits, and all eight accept settings and all eight interrupt settings. It also alternates between an end of frame that shares a cycle with the last byte and one that comes in a cycle of its own.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    localparam int STAT_W   = 16;
    localparam int BIT_DRIB = 7;
    localparam int BIT_CRC  = 12;
    localparam int BIT_RUNT = 13;
    localparam int BIT_XTRA = 14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DONE = 2'd2
    } rxc_state_t;
endpackage

// File: rtl/rxc_len_counter.sv
module rxc_len_counter #(
    parameter int MAX_LEN = 1518,
    parameter int CNT_W   = $clog2(MAX_LEN + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             eof,
    output logic [CNT_W-1:0] len_now,
    output logic             byte_store
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LEN);

    logic [CNT_W-1:0] cnt_q;

    // Length saturates at MAX_LEN+1: enough to tell oversize apart.
    always_comb begin
        len_now = cnt_q;
        if (byte_vld && (cnt_q <= MAX_C))
            len_now = cnt_q + 1'b1;
    end

    assign byte_store = byte_vld && (cnt_q < MAX_C);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (eof)
            cnt_q <= '0;
        else
            cnt_q <= len_now;
    end
endmodule

// File: rtl/rxc_status_eval.sv
module rxc_status_eval
    import rxc_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int CNT_W   = $clog2(MAX_LEN + 2)
) (
    input  logic [CNT_W-1:0]  frame_len,
    input  logic [2:0]        eof_bits,
    input  logic              crc_ok,
    input  logic [STAT_W-1:0] accept_mask,
    input  logic [STAT_W-1:0] irq_mask,
    output logic [STAT_W-1:0] status,
    output logic              keep,
    output logic              irq_hit,
    output logic              align
);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LEN);

    logic [2:0] err;
    logic [2:0] acc;
    logic [2:0] ien;
    logic       drib;

    assign drib = |eof_bits;
    assign err  = {frame_len > MAX_C, frame_len < MIN_C, !crc_ok};
    assign acc  = {accept_mask[BIT_XTRA], accept_mask[BIT_RUNT], accept_mask[BIT_CRC]};
    assign ien  = {irq_mask[BIT_XTRA], irq_mask[BIT_RUNT], irq_mask[BIT_CRC]};

    always_comb begin
        status           = '0;
        status[BIT_DRIB] = drib;
        status[BIT_CRC]  = err[0];
        status[BIT_RUNT] = err[1];
        status[BIT_XTRA] = err[2];
    end

    assign keep    = ((err & ~acc) == 3'b000);
    assign irq_hit = |(err & ien);
    assign align   = drib && err[0];
endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
    import rxc_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              eof,
    input  logic [2:0]        eof_bits,
    input  logic              crc_ok,
    input  logic [STAT_W-1:0] accept_mask,
    input  logic [STAT_W-1:0] irq_mask,
    output logic              byte_store,
    output logic              res_vld,
    output logic [STAT_W-1:0] res_status,
    output logic              res_keep,
    output logic              res_align,
    output logic              irq
);
    localparam int CNT_W = $clog2(MAX_LEN + 2);

    rxc_state_t        state_q, state_d;
    logic [CNT_W-1:0]  frame_len;
    logic [STAT_W-1:0] nxt_status;
    logic              nxt_keep, nxt_irq, nxt_align;
    logic              irq_q;

    rxc_len_counter #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .eof        (eof),
        .len_now    (frame_len),
        .byte_store (byte_store)
    );

    rxc_status_eval #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_eval (
        .frame_len   (frame_len),
        .eof_bits    (eof_bits),
        .crc_ok      (crc_ok),
        .accept_mask (accept_mask),
        .irq_mask    (irq_mask),
        .status      (nxt_status),
        .keep        (nxt_keep),
        .irq_hit     (nxt_irq),
        .align       (nxt_align)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (eof) state_d = ST_DONE;
                     else if (byte_vld) state_d = ST_RECV;
            ST_RECV: if (eof) state_d = ST_DONE;
            ST_DONE: if (eof) state_d = ST_DONE;
                     else if (byte_vld) state_d = ST_RECV;
                     else state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_status <= '0;
            res_keep   <= 1'b0;
            res_align  <= 1'b0;
            irq_q      <= 1'b0;
        end else if (eof) begin
            res_status <= nxt_status;
            res_keep   <= nxt_keep;
            res_align  <= nxt_align;
            irq_q      <= nxt_irq;
        end
    end

    assign res_vld = (state_q == ST_DONE);
    assign irq     = res_vld && irq_q;
endmodule

// File: rtl/rx_frame_classifier_chk.sv
module rx_frame_classifier_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        byte_vld,
    input logic        eof,
    input logic [2:0]  eof_bits,
    input logic        crc_ok,
    input logic        byte_store,
    input logic        res_vld,
    input logic [15:0] res_status,
    input logic        res_keep,
    input logic        res_align,
    input logic        irq
);
    p_crc_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eof && !crc_ok |=> res_status[12]);
    p_store_needs_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_store |-> byte_vld);
    p_dribble_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eof && (eof_bits != 3'd0) |=> res_status[7]);
    p_align_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_align == (res_status[7] && res_status[12])));
    p_clean_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld && (res_status[14:12] == 3'b000) |-> res_keep);
    p_irq_in_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> res_vld && (res_status[14:12] != 3'b000));
    p_strobe_after_eof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> res_vld);
    p_strobe_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(eof));
endmodule

bind rx_frame_classifier rx_frame_classifier_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .eof        (eof),
    .eof_bits   (eof_bits),
    .crc_ok     (crc_ok),
    .byte_store (byte_store),
    .res_vld    (res_vld),
    .res_status (res_status),
    .res_keep   (res_keep),
    .res_align  (res_align),
    .irq        (irq)
);

// File: tb/rx_frame_classifier_test.sv
module rx_frame_classifier_test;
    localparam int MINL = 4;
    localparam int MAXL = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic        eof = 1'b0;
    logic [2:0]  eof_bits = 3'd0;
    logic        crc_ok = 1'b1;
    logic [15:0] accept_mask = 16'd0;
    logic [15:0] irq_mask = 16'd0;
    logic        byte_store, res_vld, res_keep, res_align, irq;
    logic [15:0] res_status;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rx_frame_classifier #(.MIN_LEN(MINL), .MAX_LEN(MAXL)) uut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .eof(eof),
        .eof_bits(eof_bits), .crc_ok(crc_ok), .accept_mask(accept_mask),
        .irq_mask(irq_mask), .byte_store(byte_store), .res_vld(res_vld),
        .res_status(res_status), .res_keep(res_keep), .res_align(res_align),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input int len, input logic [2:0] bits, input logic good,
                             input int am, input int im, input logic joint);
        logic [15:0] st;
        logic [2:0]  err;
        int          nb;
        nb = joint && len > 0 ? len - 1 : len;
        accept_mask = 16'(am) << 12;
        irq_mask    = 16'(im) << 12;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            #1;
            chk("R4 store", 32'(byte_store), 32'(i < MAXL));
        end
        @(negedge clk);
        byte_vld = joint && len > 0;
        eof = 1'b1; eof_bits = bits; crc_ok = good;
        #1;
        if (byte_vld) chk("R4 store last", 32'(byte_store), 32'(nb < MAXL));
        chk("R9 no early strobe", 32'(res_vld), 32'(0));
        @(negedge clk);
        byte_vld = 1'b0; eof = 1'b0; eof_bits = 3'd0; crc_ok = 1'b1;
        st = '0;
        st[7]  = (bits != 3'd0);
        st[12] = !good;
        st[13] = (len < MINL);
        st[14] = (len > MAXL);
        err = st[14:12];
        #1;
        chk("R9 strobe", 32'(res_vld), 32'(1));
        chk("R1 R2 R3 R5 R9 status", 32'(res_status), 32'(st));
        chk("R6 align", 32'(res_align), 32'((bits != 3'd0) && !good));
        chk("R7 keep", 32'(res_keep), 32'((err & ~3'(am)) == 3'd0));
        chk("R8 irq", 32'(irq), 32'((err & 3'(im)) != 3'd0));
        @(negedge clk);
        #1;
        chk("R9 single cycle", 32'(res_vld), 32'(0));
        chk("R8 irq clear", 32'(irq), 32'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset vld", 32'(res_vld), 32'(0));
        chk("R10 reset irq", 32'(irq), 32'(0));
        chk("R10 reset status", 32'(res_status), 32'(0));
        rst_n = 1'b1;
        for (int len = 0; len <= MAXL + 3; len++)
            for (int g = 0; g < 2; g++)
                for (int b = 0; b < 2; b++)
                    for (int am = 0; am < 8; am++)
                        for (int im = 0; im < 8; im++)
                            run_frame(len, b ? 3'd5 : 3'd0, g[0], am, im, am[0] ^ im[0]);
        run_frame(MAXL + 1, 3'd7, 1'b0, 7, 0, 1'b1);
        run_frame(MINL, 3'd1, 1'b1, 0, 7, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule